// File: doc/BRIEF.md
# DMA Channel Command and State Controller

This block is the per-channel control word and channel state machine of a descriptor-ring DMA engine. Software writes a command code into one byte of a 32-bit control word. The channel then steps through its states, and software reads the current state back from a second, read-only byte of the same word. The remaining bits of the word are plain control bits that keep whatever was last written. A driver can therefore read the word, change only the command byte and write it back without disturbing anything else.

Two outputs tell the rest of the engine what the channel is doing. `fetch_en` is high while descriptors may be fetched, and `chan_ok` is high while the channel counts as healthy. The engine reports back through two inputs: `work_avail` means descriptors are waiting, and `xfer_busy` means transfers are still in flight. A suspend waits until the in-flight transfers have drained. A reset command walks the channel back to disabled after a fixed, configurable quiesce time.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the whole control word reads zero (state disabled, code 0), and `fetch_en` and `chan_ok` are low.
- R2: The command byte is bits 23:16 and reads back the last value written there. The state byte is bits 15:8. The state codes are 0 disabled, 1 enabled, 2 running, 3 suspended and 4 stopped (quiescing). The command codes are 0 disable, 1 enable, 2 suspend and 9 reset.
- R3: An enable command written while the channel is disabled or suspended makes it enabled on the next cycle.
- R4: An enabled channel with `work_avail` high becomes running on the next cycle. A running channel returns to enabled once `work_avail` and `xfer_busy` are both low.
- R5: A suspend command written while the channel is enabled or running moves it to stopped, with `fetch_en` low. It stays stopped while `xfer_busy` is high, and it reads suspended on the first cycle after `xfer_busy` is seen low.
- R6: A reset command from any state shows stopped for RST_CYCLES cycles and then disabled. `fetch_en` stays low throughout.
- R7: A disable command written while the channel is enabled, running or suspended makes it disabled on the next cycle.
- R8: A command code other than 0, 1, 2 or 9 leaves the state unchanged.
- R9: Writes to bits 15:8 have no effect on the reported state.
- R10: Bits 31:24 and 7:0 read back the last value written to them. A read-modify-write that changes only the command byte leaves them unchanged.
- R11: `chan_ok` is high exactly in the enabled and running states, and `fetch_en` is high only in the running state.
- R12: While the channel is stopped, disable, enable and suspend commands are ignored. A new reset command restarts the full quiesce time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word: control bits, command byte, state byte |
| work_avail | input | 1 | Descriptors are waiting to be fetched |
| xfer_busy | input | 1 | Transfers are still in flight |
| fetch_en | output | 1 | Channel may fetch descriptors (running) |
| chan_ok | output | 1 | Channel is enabled or running |

## Verification
The assertions assume that `work_avail` and `xfer_busy` are ordinary levels that change only between clock edges. They also assume that a single write carries both the command byte and the control bits. The drain assertion assumes that `xfer_busy` eventually falls. The stimulus changes every input on the falling edge and always drops `xfer_busy` after a few cycles of holding it. It sweeps every unknown command byte from two settled states and checks each quiesce cycle one by one.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic [2:0] {
      CH_OFF, CH_IDLE, CH_RUN, CH_HOLD, CH_DRAIN, CH_QUIESCE
   } ch_st_e;

   localparam int CMD_OFF   = 0;
   localparam int CMD_ON    = 1;
   localparam int CMD_HOLD  = 2;
   localparam int CMD_CLEAR = 9;

   typedef struct packed {
      logic off;
      logic on;
      logic hold;
      logic clear;
   } dcc_cmd_t;

   function automatic logic [7:0] st_code(ch_st_e s);
      case (s)
         CH_OFF:   return 8'd0;
         CH_IDLE:  return 8'd1;
         CH_RUN:   return 8'd2;
         CH_HOLD:  return 8'd3;
         default:  return 8'd4;
      endcase
   endfunction
endpackage

// File: rtl/dcc_cmd_decode.sv
module dcc_cmd_decode
   import dcc_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic               wr,
   input  logic [FIELD_W-1:0] code,
   output dcc_cmd_t           cmd
);
   always_comb begin
      cmd.off   = wr && (code == FIELD_W'(CMD_OFF));
      cmd.on    = wr && (code == FIELD_W'(CMD_ON));
      cmd.hold  = wr && (code == FIELD_W'(CMD_HOLD));
      cmd.clear = wr && (code == FIELD_W'(CMD_CLEAR));
   end
endmodule

// File: rtl/dcc_state_fsm.sv
module dcc_state_fsm
   import dcc_pkg::*;
#(
   parameter int RST_CYCLES = 5,
   localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  dcc_cmd_t cmd,
   input  logic     work_avail,
   input  logic     xfer_busy,
   output ch_st_e   st,
   output logic     fetch_en,
   output logic     chan_ok
);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

   ch_st_e           nxt;
   logic [CNT_W-1:0] cnt, cnt_n;

   always_comb begin
      nxt   = st;
      cnt_n = cnt;
      if (cmd.clear) begin
         nxt   = CH_QUIESCE;
         cnt_n = LOAD;
      end else begin
         unique case (st)
            CH_OFF:  if (cmd.on) nxt = CH_IDLE;
            CH_IDLE: begin
               if (cmd.off)        nxt = CH_OFF;
               else if (cmd.hold)  nxt = CH_DRAIN;
               else if (work_avail) nxt = CH_RUN;
            end
            CH_RUN: begin
               if (cmd.off)       nxt = CH_OFF;
               else if (cmd.hold) nxt = CH_DRAIN;
               else if (!work_avail && !xfer_busy) nxt = CH_IDLE;
            end
            CH_HOLD: begin
               if (cmd.off)     nxt = CH_OFF;
               else if (cmd.on) nxt = CH_IDLE;
            end
            CH_DRAIN: if (!xfer_busy) nxt = CH_HOLD;
            CH_QUIESCE: begin
               if (cnt == '0) nxt = CH_OFF;
               else           cnt_n = cnt - 1'b1;
            end
            default: nxt = CH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CH_OFF;
         cnt <= '0;
      end else begin
         st  <= nxt;
         cnt <= cnt_n;
      end
   end

   assign fetch_en = (st == CH_RUN);
   assign chan_ok  = (st == CH_IDLE) || (st == CH_RUN);

   AST_DRAIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_DRAIN && xfer_busy && !cmd.clear) |=> (st == CH_DRAIN)); // R5
   AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_DRAIN && !xfer_busy && !cmd.clear) |=> (st == CH_HOLD)); // R5
   AST_QUIESCE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_QUIESCE && cnt == '0 && !cmd.clear) |=> (st == CH_OFF)); // R6
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD); // R6
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.clear |=> (st == CH_QUIESCE && cnt == LOAD)); // R12
   AST_FETCH_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |-> chan_ok); // R11
endmodule

// File: rtl/dcc_csr.sv
module dcc_csr #(
   parameter int DATA_W       = 32,
   parameter int FIELD_W      = 8,
   parameter int CMD_LSB      = 16,
   parameter int STATE_LSB    = 8,
   parameter bit CMD_READBACK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [FIELD_W-1:0] state_code,
   output logic [DATA_W-1:0]  rdata
);
   localparam logic [DATA_W-1:0] FMASK     = {{(DATA_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};
   localparam logic [DATA_W-1:0] KEEP_MASK = ~((FMASK << CMD_LSB) | (FMASK << STATE_LSB));

   logic [DATA_W-1:0]  keep_q;
   logic [FIELD_W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  keep_q <= '0;
      else if (wr) keep_q <= wdata & KEEP_MASK;
   end

   if (CMD_READBACK) begin : g_cmd_rb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  cmd_q <= '0;
         else if (wr) cmd_q <= wdata[CMD_LSB +: FIELD_W];
      end
   end else begin : g_cmd_zero
      assign cmd_q = '0;
   end

   always_comb begin
      rdata = keep_q;
      rdata[CMD_LSB +: FIELD_W]   = cmd_q;
      rdata[STATE_LSB +: FIELD_W] = state_code;
   end

   AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(keep_q)); // R10
   AST_KEEP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_q & ~KEEP_MASK) == '0); // R9
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dcc_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int FIELD_W      = 8,
   parameter int CMD_LSB      = 16,
   parameter int STATE_LSB    = 8,
   parameter int RST_CYCLES   = 5,
   parameter bit CMD_READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              work_avail,
   input  logic              xfer_busy,
   output logic              fetch_en,
   output logic              chan_ok
);
   if (FIELD_W < 4) begin : g_bad_field
      $error("FIELD_W too narrow for command code 9");
   end
   if (CMD_LSB + FIELD_W > DATA_W || STATE_LSB + FIELD_W > DATA_W) begin : g_bad_pos
      $error("field exceeds control word");
   end
   if ((CMD_LSB < STATE_LSB + FIELD_W) && (STATE_LSB < CMD_LSB + FIELD_W)) begin : g_bad_ovl
      $error("command and state fields overlap");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   dcc_cmd_t cmd;
   ch_st_e   st;

   dcc_cmd_decode #(.FIELD_W(FIELD_W)) i_dec (
      .wr   (reg_wr),
      .code (reg_wdata[CMD_LSB +: FIELD_W]),
      .cmd  (cmd)
   );

   dcc_state_fsm #(.RST_CYCLES(RST_CYCLES)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .work_avail (work_avail),
      .xfer_busy  (xfer_busy),
      .st         (st),
      .fetch_en   (fetch_en),
      .chan_ok    (chan_ok)
   );

   dcc_csr #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CMD_LSB(CMD_LSB),
      .STATE_LSB(STATE_LSB), .CMD_READBACK(CMD_READBACK)
   ) i_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .wdata      (reg_wdata),
      .state_code (FIELD_W'(st_code(st))),
      .rdata      (reg_rdata)
   );

   AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && cmd == '0 && reg_wdata[CMD_LSB +: FIELD_W] != FIELD_W'(CMD_OFF)
       && reg_rdata[STATE_LSB +: FIELD_W] == FIELD_W'(3))
      |=> (reg_rdata[STATE_LSB +: FIELD_W] == FIELD_W'(3))); // R8
   AST_OK_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_ok == (reg_rdata[STATE_LSB +: FIELD_W] == FIELD_W'(1) ||
                  reg_rdata[STATE_LSB +: FIELD_W] == FIELD_W'(2))); // R11
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
   localparam int RC = 5;
   localparam logic [31:0] KEEP = 32'hFF0000FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        work_avail = 1'b0;
   logic        xfer_busy = 1'b0;
   logic        fetch_en, chan_ok;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_chan_ctl #(.RST_CYCLES(RC)) i_dma_chan_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .work_avail(work_avail), .xfer_busy(xfer_busy),
      .fetch_en(fetch_en), .chan_ok(chan_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_st(input string req, input int code);
      chk(req, {24'd0, reg_rdata[15:8]}, code);
      chk({req, " ok"}, {31'd0, chan_ok}, (code == 1 || code == 2) ? 1 : 0);
      chk({req, " fetch"}, {31'd0, fetch_en}, (code == 2) ? 1 : 0);
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R1 word", reg_rdata, 32'd0);
      chk_st("R1", 0);

      // R9: writing the state byte while disabled does nothing
      wr(32'h0000_FF00);
      chk_st("R9 off", 0);

      // R3 / R2: enable from disabled
      wr(32'h0001_0000);
      chk_st("R3", 1);
      chk("R2 cmd readback", {24'd0, reg_rdata[23:16]}, 1);

      // R4: enabled <-> running
      work_avail = 1'b1; tick();
      chk_st("R4 run", 2);
      work_avail = 1'b0; xfer_busy = 1'b1; tick();
      chk_st("R4 busy keeps run", 2);
      xfer_busy = 1'b0; tick();
      chk_st("R4 idle", 1);

      // R8: every unknown code from enabled
      for (int c = 0; c < 256; c++) begin
         if (!(c inside {0, 1, 2, 9})) begin
            wr(32'(c) << 16);
            chk("R8 from enabled", {24'd0, reg_rdata[15:8]}, 1);
         end
      end

      // R5 / R12: suspend from running with work in flight
      work_avail = 1'b1; tick();
      chk_st("R4 run again", 2);
      xfer_busy = 1'b1;
      wr(32'h0002_0000);
      chk_st("R5 stopped", 4);
      tick(); chk_st("R5 draining", 4);
      wr(32'h0001_0000);
      chk_st("R12 enable ignored", 4);
      wr(32'h0000_0000);
      chk_st("R12 disable ignored", 4);
      work_avail = 1'b0; xfer_busy = 1'b0; tick();
      chk_st("R5 suspended", 3);

      // R9 / R8 from suspended
      wr(32'h0055_FF00);
      chk_st("R9 hold", 3);
      for (int c = 0; c < 256; c++) begin
         if (!(c inside {0, 1, 2, 9})) begin
            wr((32'(c) << 16) | 32'h0000_AA00);
            chk("R8 from suspended", {24'd0, reg_rdata[15:8]}, 3);
         end
      end
      wr(32'h0002_0000);
      chk_st("R5 suspend in suspended ignored", 3);

      // R10: control bit patterns, then read-modify-write
      for (int i = 0; i < 16; i++) begin
         logic [31:0] p;
         p = {8'(i * 17), 8'h77, 8'h00, 8'(8'hA5 ^ 8'(i * 29))};
         wr(p);
         chk("R10 keep", reg_rdata & KEEP, p & KEEP);
         chk("R2 cmd byte", {24'd0, reg_rdata[23:16]}, 32'h77);
      end
      begin
         logic [31:0] v, kept;
         v = reg_rdata;
         kept = v & KEEP;
         v[23:16] = 8'd1;
         wr(v);
         chk("R10 rmw keep", reg_rdata & KEEP, kept);
         chk_st("R3 from suspended", 1);
      end

      // R7: disable from enabled, suspended, running
      wr(32'h0000_0000);
      chk_st("R7 from enabled", 0);
      wr(32'h0001_0000);
      wr(32'h0002_0000);
      chk_st("R5 no busy", 4);
      tick();
      chk_st("R5 suspended quickly", 3);
      wr(32'h0000_0000);
      chk_st("R7 from suspended", 0);
      wr(32'h0002_0000);
      chk_st("R5 suspend in disabled ignored", 0);
      wr(32'h0001_0000);
      work_avail = 1'b1; tick();
      wr(32'h0000_0000);
      chk_st("R7 from running", 0);
      work_avail = 1'b0;

      // R6 / R12: reset from running, with restart
      wr(32'h0001_0000);
      work_avail = 1'b1; tick();
      chk_st("R6 pre run", 2);
      wr(32'h0009_0000);
      chk_st("R6 q0", 4);
      tick(); chk_st("R6 q1", 4);
      tick(); chk_st("R6 q2", 4);
      wr(32'h0009_0000);
      chk_st("R12 restart", 4);
      for (int j = 1; j < RC; j++) begin
         tick();
         chk_st("R6 quiesce", 4);
      end
      tick();
      chk_st("R6 disabled", 0);
      work_avail = 1'b0;

      // R6: reset from disabled and from suspended (busy ignored)
      wr(32'h0009_0000);
      for (int j = 1; j < RC; j++) begin
         tick();
         chk_st("R6 from off", 4);
      end
      tick();
      chk_st("R6 off done", 0);
      wr(32'h0001_0000);
      wr(32'h0002_0000);
      tick();
      xfer_busy = 1'b1;
      wr(32'h0009_0000);
      for (int j = 1; j < RC; j++) begin
         tick();
         chk_st("R6 from hold", 4);
      end
      tick();
      chk_st("R6 hold done", 0);
      xfer_busy = 1'b0;

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule